// File: doc/BRIEF.md
# Sixty-Four Input Interrupt Gatherer

The block collects sixty-four raw interrupt lines into a single request toward an upstream interrupt controller. Software reaches it through a plain 32-bit register bus: an address, a write strobe, write data, and combinational read data. Each source has its own configuration word. That word holds a pair of unmask bits and a two-bit sense code. Two global switches gate the block. One turns detection on and the other lets the request leave the block.

All inputs pass through a two-flop synchronizer. Most sources are level-only, so they are pending while their synchronized input sits at the configured polarity. Four sources, 47 to 50, can also be set for rising or falling edges. An edge on one of them sets a latch that holds until software clears it through a dedicated clear register. The clear register takes a four-bit index in the low bits of the write data.

A status register reports the lowest-numbered pending, unmasked source in its top byte. The value 63 in that byte means nothing is pending. The request output is high whenever the status names a real source and both global switches are on.

Top module: `irq_hub`

## Requirements
- R1: After reset the status register (offset 0x144) reads 0x3F000000 and irq_req is low. The detection-enable (0x004), output-enable (0x444) and mask-level (0x084) registers read zero. Every source's first configuration word reads 0x01000000, which means masked with sense code 1.
- R2: Source n's first configuration word is at 0x200+8n and its second word is at 0x200+8n+4. The first word keeps only bits 29:28 and 25:24 and reads every other bit as zero. The second word always reads zero, and writes to it have no effect.
- R3: A source can become pending only when both bit 29 and bit 28 of its first word are 1. With only one of the two bits set, the source stays masked.
- R4: A level source with sense bit 24 set is pending while its input is high. With bit 24 clear it is pending while its input is low. A change on the input shows in the status after the second rising clock edge.
- R5: On sources outside 47..50, sense bit 25 is ignored and bit 24 alone picks the level polarity. This holds for codes 2 and 3 as well.
- R6: On sources 47..50, sense code 3 latches a rising edge and code 2 latches a falling edge. The latch is set after the third rising edge following the input transition. It stays set after the input returns, whatever the per-source unmask bits are.
- R7: A write to offset 0x0C0 with bit 8 set clears the edge latch of the source whose number modulo 16 equals write-data bits 3:0: 15 selects 47, 0 selects 48, 1 selects 49 and 2 selects 50. The clear takes effect on the writing clock edge. A write with bit 8 clear, or an index naming another source, leaves the latch set. If a new edge arrives in the same cycle as the clear, the latch stays set.
- R8: Status bits 31:24 hold the lowest-numbered pending unmasked source among 0..62. All other status bits read zero. The byte reads 63 when no such source is pending, and source 63 is never reported.
- R9: Bit 0 at offset 0x004 enables detection. While it is 0 the status reads 63 and edge latches capture nothing. A level source already active appears in the status right after the write that sets this bit.
- R10: Bit 0 at offset 0x444 enables output. irq_req is high exactly when detection is enabled, output is enabled, and the status byte is not 63.
- R11: The mask-level register at 0x084 reads back all 32 bits written to it. Its value never changes which source the status reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | 64 | Raw interrupt inputs, one per source |
| irq_req | output | 1 | Request toward the upstream controller |

## Verification
Each result has a fixed arrival time. A level input change reaches the status after two rising edges and a latched edge after three. A register write takes effect on the edge that captures it, so it is visible at the following falling edge. The bench drives every input at a falling edge and counts rising edges before it samples at a later falling edge. For the level and edge paths it also checks one edge early that the old value is still present. This pins the synchronizer depth exactly, rather than only bounding it. The sweeps walk a single source across all 63 reportable numbers, retire sources one by one from a full set to exercise priority, and run arithmetic input patterns. Each expected code comes from a lowest-set-bit model in the bench.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam logic [11:0] OFS_DETEN   = 12'h004;
    localparam logic [11:0] OFS_MASKLVL = 12'h084;
    localparam logic [11:0] OFS_EDGECLR = 12'h0C0;
    localparam logic [11:0] OFS_STATUS  = 12'h144;
    localparam logic [11:0] OFS_CFGBASE = 12'h200;
    localparam logic [11:0] OFS_OUTEN   = 12'h444;

    localparam int CLR_ARM_BIT = 8;

    typedef enum logic [1:0] {
        SENSE_LVL_LO = 2'd0,
        SENSE_LVL_HI = 2'd1,
        SENSE_FALL   = 2'd2,
        SENSE_RISE   = 2'd3
    } sense_t;

    typedef enum logic {
        EDGE_IDLE = 1'b0,
        EDGE_HELD = 1'b1
    } edge_st_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= raw;
            stab_q <= meta_q;
        end
    end

    assign synced = stab_q;
endmodule

// File: rtl/irq_edge_cell.sv
module irq_edge_cell
    import irq_hub_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cur,
    input  sense_t sense,
    input  logic   det_en,
    input  logic   clr,
    output logic   held
);
    logic     prev_q;
    logic     hit;
    edge_st_t st_q, st_d;

    always_comb begin
        unique case (sense)
            SENSE_RISE: hit = det_en & cur & ~prev_q;
            SENSE_FALL: hit = det_en & ~cur & prev_q;
            default:    hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= EDGE_IDLE;
            prev_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            prev_q <= cur;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EDGE_IDLE: if (hit)         st_d = EDGE_HELD;
            EDGE_HELD: if (clr && !hit) st_d = EDGE_IDLE;
            default:                    st_d = EDGE_IDLE;
        endcase
    end

    always_comb begin
        held = (st_q == EDGE_HELD);
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter  int NUM_SRC = 64,
    localparam int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-2:0] pend,
    output logic [SRC_W-1:0]   sel
);
    always_comb begin
        sel = SRC_W'(NUM_SRC - 1);
        for (int i = NUM_SRC - 2; i >= 0; i--) begin
            if (pend[i]) sel = SRC_W'(i);
        end
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter  int NUM_SRC = 64,
    parameter  int EDGE_LO = 47,
    parameter  int EDGE_HI = 50,
    parameter  int ADDR_W  = 12,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int EDGE_N  = EDGE_HI - EDGE_LO + 1,
    localparam int CFG_SPAN = 8 * NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic               irq_req
);
    localparam logic [SRC_W-1:0] NONE = SRC_W'(NUM_SRC - 1);

    logic                    det_en_q, out_en_q;
    logic [31:0]             mask_lvl_q;
    logic [NUM_SRC-1:0][1:0] cfg_en_q;
    logic [NUM_SRC-1:0][1:0] cfg_sense_q;

    logic [ADDR_W-1:0] cfg_off;
    logic              cfg_hit;
    logic [SRC_W-1:0]  cfg_idx;
    logic              clr_req;
    logic [NUM_SRC-1:0] lvl_sync, active, pend_vec;
    logic [EDGE_N-1:0] edge_held, edge_clr_v;
    logic [SRC_W-1:0]  pick_src;

    // Address decode for the per-source configuration window
    always_comb begin
        cfg_off = bus_addr - ADDR_W'(OFS_CFGBASE);
        cfg_hit = (bus_addr >= ADDR_W'(OFS_CFGBASE)) &&
                  (cfg_off < ADDR_W'(CFG_SPAN)) && (cfg_off[1:0] == 2'b00);
        cfg_idx = SRC_W'(cfg_off[ADDR_W-1:3]);
        clr_req = bus_we && (bus_addr == ADDR_W'(OFS_EDGECLR)) && bus_wdata[CLR_ARM_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_en_q    <= 1'b0;
            out_en_q    <= 1'b0;
            mask_lvl_q  <= '0;
            cfg_en_q    <= '0;
            cfg_sense_q <= {NUM_SRC{SENSE_LVL_HI}};
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(OFS_DETEN))   det_en_q   <= bus_wdata[0];
            if (bus_addr == ADDR_W'(OFS_OUTEN))   out_en_q   <= bus_wdata[0];
            if (bus_addr == ADDR_W'(OFS_MASKLVL)) mask_lvl_q <= bus_wdata;
            if (cfg_hit && !cfg_off[2]) begin
                cfg_en_q[cfg_idx]    <= bus_wdata[29:28];
                cfg_sense_q[cfg_idx] <= bus_wdata[25:24];
            end
        end
    end

    irq_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (irq_in),
        .synced (lvl_sync)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (g >= EDGE_LO && g <= EDGE_HI) begin : g_edge
            localparam logic [3:0] NIB = 4'(g % 16);
            logic held;
            assign edge_clr_v[g-EDGE_LO] = clr_req && (bus_wdata[3:0] == NIB);
            irq_edge_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .cur    (lvl_sync[g]),
                .sense  (sense_t'(cfg_sense_q[g])),
                .det_en (det_en_q),
                .clr    (edge_clr_v[g-EDGE_LO]),
                .held   (held)
            );
            assign edge_held[g-EDGE_LO] = held;
            assign active[g] = cfg_sense_q[g][1] ? held
                                                 : (lvl_sync[g] == cfg_sense_q[g][0]);
        end else begin : g_lvl
            assign active[g] = (lvl_sync[g] == cfg_sense_q[g][0]);
        end
        assign pend_vec[g] = det_en_q & (&cfg_en_q[g]) & active[g];
    end

    irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .pend (pend_vec[NUM_SRC-2:0]),
        .sel  (pick_src)
    );

    assign irq_req = det_en_q && out_en_q && (pick_src != NONE);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_DETEN)) begin
            bus_rdata[0] = det_en_q;
        end else if (bus_addr == ADDR_W'(OFS_OUTEN)) begin
            bus_rdata[0] = out_en_q;
        end else if (bus_addr == ADDR_W'(OFS_MASKLVL)) begin
            bus_rdata = mask_lvl_q;
        end else if (bus_addr == ADDR_W'(OFS_STATUS)) begin
            bus_rdata[31:24] = 8'(pick_src);
        end else if (cfg_hit && !cfg_off[2]) begin
            bus_rdata[29:28] = cfg_en_q[cfg_idx];
            bus_rdata[25:24] = cfg_sense_q[cfg_idx];
        end
    end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
    parameter  int NUM_SRC = 64,
    parameter  int EDGE_N  = 4,
    localparam int SRC_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_req,
    input logic               det_en,
    input logic               out_en,
    input logic [SRC_W-1:0]   pick,
    input logic [NUM_SRC-1:0] pend_vec,
    input logic [EDGE_N-1:0]  edge_held,
    input logic [EDGE_N-1:0]  edge_clr
);
    localparam logic [SRC_W-1:0] NONE = SRC_W'(NUM_SRC - 1);

    logic [NUM_SRC-1:0] below;
    always_comb below = pend_vec & ((NUM_SRC'(1) << pick) - NUM_SRC'(1));

    // R8
    pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick != NONE) |-> (pend_vec[pick] && (below == '0)));

    // R8
    pick_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick == NONE) |-> (pend_vec[NUM_SRC-2:0] == '0));

    // R10
    req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (out_en && pend_vec[pick]));

    // R10
    req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !irq_req);

    // R9
    edge_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_held & ~$past(edge_held)) != '0) |-> $past(det_en));

    for (genvar i = 0; i < EDGE_N; i++) begin : g_hold
        // R6
        edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_held[i] && !edge_clr[i]) |=> edge_held[i]);
    end
endmodule

bind irq_hub irq_hub_chk #(.NUM_SRC(NUM_SRC), .EDGE_N(EDGE_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .det_en    (det_en_q),
    .out_en    (out_en_q),
    .pick      (pick_src),
    .pend_vec  (pend_vec),
    .edge_held (edge_held),
    .edge_clr  (edge_clr_v)
);

// File: tb/tb_irq_hub.sv
module tb_irq_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_in = '0;
    logic        irq_req;

    int checks = 0;
    int failures = 0;
    logic [31:0] v;
    logic [63:0] en_model;

    irq_hub dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_req(irq_req)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] st(input int n);
        return {8'(n), 24'h0};
    endfunction

    function automatic int lowest(input logic [63:0] en, input logic [63:0] inp);
        for (int i = 0; i < 63; i++) if (en[i] && inp[i]) return i;
        return 63;
    endfunction

    function automatic logic [11:0] cfg(input int n);
        return 12'(12'h200 + 8 * n);
    endfunction

    task automatic chk_st(input string tag, input int n);
        rd(12'h144, v);
        chk(tag, {32'h0, v}, {32'h0, st(n)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk_st("R1 status", 63);
        chk("R1 irq_req", {63'h0, irq_req}, 64'h0);
        rd(cfg(5), v);     chk("R1 cfg word0", {32'h0, v}, 64'h01000000);
        rd(12'h004, v);    chk("R1 deten", {32'h0, v}, 64'h0);
        rd(12'h444, v);    chk("R1 outen", {32'h0, v}, 64'h0);
        rd(12'h084, v);    chk("R1 masklvl", {32'h0, v}, 64'h0);

        // R2 layout of configuration words
        wr(cfg(5) + 12'd4, 32'hFFFF_FFFF);
        rd(cfg(5) + 12'd4, v); chk("R2 word1 zero", {32'h0, v}, 64'h0);
        rd(cfg(5), v);     chk("R2 word1 no effect", {32'h0, v}, 64'h01000000);
        wr(cfg(5), 32'hFFFF_FFFF);
        rd(cfg(5), v);     chk("R2 word0 kept bits", {32'h0, v}, 64'h33000000);
        wr(cfg(5), 32'h0100_0000);

        // R11 mask-level readback
        wr(12'h084, 32'hA5A5_5A5A);
        rd(12'h084, v);    chk("R11 masklvl readback", {32'h0, v}, 64'hA5A55A5A);

        wr(12'h004, 32'h1);
        wr(12'h444, 32'h1);

        // R4 R8 single-source sweep with latency
        for (int n = 0; n < 63; n++) begin
            wr(cfg(n), 32'h3100_0000);
            irq_in = 64'h1 << n;
            tick(1);
            chk_st("R4 one edge early", 63);
            tick(1);
            chk_st("R4 sweep", n);
            chk("R10 req on", {63'h0, irq_req}, 64'h1);
            irq_in = '0;
            wr(cfg(n), 32'h0100_0000);
        end

        // R8 source 63 never reported
        wr(cfg(63), 32'h3100_0000);
        irq_in = 64'h1 << 63;
        tick(3);
        chk_st("R8 source 63", 63);
        chk("R10 req off for 63", {63'h0, irq_req}, 64'h0);
        irq_in = '0;
        wr(cfg(63), 32'h0100_0000);

        // R8 priority: retire sources one by one
        for (int n = 0; n < 63; n++) wr(cfg(n), 32'h3100_0000);
        en_model = {1'b0, {63{1'b1}}};
        irq_in = '1;
        tick(2);
        for (int k = 0; k < 63; k++) begin
            chk_st("R8 priority", lowest(en_model, irq_in));
            irq_in[k] = 1'b0;
            tick(2);
        end
        chk_st("R8 none left", 63);

        // R8 arithmetic patterns
        for (int p = 1; p <= 12; p++) begin
            irq_in = {32'(p * 32'h9E3779B9), 32'(p * 32'h85EBCA6B)} << (p * 3);
            tick(2);
            chk_st("R8 pattern", lowest(en_model, irq_in));
        end
        irq_in = '0;
        tick(2);

        // R3 both unmask bits needed
        irq_in[3] = 1'b1;
        wr(cfg(3), 32'h2100_0000); tick(2);
        chk_st("R3 bit29 only", 63);
        wr(cfg(3), 32'h1100_0000); tick(1);
        chk_st("R3 bit28 only", 63);
        wr(cfg(3), 32'h3100_0000);
        chk_st("R3 both bits", 3);
        irq_in[3] = 1'b0;
        tick(2);

        // R4 level low
        wr(cfg(10), 32'h3000_0000);
        chk_st("R4 level low active", 10);
        irq_in[10] = 1'b1;
        tick(2);
        chk_st("R4 level low released", 63);
        wr(cfg(10), 32'h3100_0000);
        irq_in[10] = 1'b0;

        // R5 level-only sources ignore bit 25
        wr(cfg(20), 32'h3300_0000);
        irq_in[20] = 1'b1; tick(2);
        chk_st("R5 code3 as level high", 20);
        irq_in[20] = 1'b0; tick(2);
        chk_st("R5 code3 no latch", 63);
        wr(cfg(21), 32'h3200_0000);
        chk_st("R5 code2 as level low", 21);
        wr(cfg(21), 32'h3100_0000);
        wr(cfg(20), 32'h3100_0000);

        // R6 rising edge on 48
        wr(cfg(48), 32'h3300_0000);
        irq_in[48] = 1'b1; tick(2);
        chk_st("R6 rise one edge early", 63);
        tick(1);
        chk_st("R6 rise latched", 48);
        irq_in[48] = 1'b0; tick(3);
        chk_st("R6 rise held", 48);
        // R7 clear behaviour
        wr(12'h0C0, 32'h0000_0000);
        chk_st("R7 no arm bit", 48);
        wr(12'h0C0, 32'h0000_0101);
        chk_st("R7 other index", 48);
        wr(12'h0C0, 32'h0000_0100);
        chk_st("R7 clear 48", 63);

        // R6 falling edge on 47, R7 index 15
        wr(cfg(47), 32'h3200_0000);
        irq_in[47] = 1'b1; tick(3);
        chk_st("R6 fall ignores rise", 63);
        irq_in[47] = 1'b0; tick(2);
        chk_st("R6 fall one edge early", 63);
        tick(1);
        chk_st("R6 fall latched", 47);
        wr(12'h0C0, 32'h0000_010F);
        chk_st("R7 clear 47", 63);

        // R9 detection disabled
        wr(12'h004, 32'h0);
        wr(cfg(50), 32'h3300_0000);
        irq_in[5] = 1'b1;
        irq_in[50] = 1'b1; tick(3);
        chk_st("R9 det off status", 63);
        chk("R9 det off req", {63'h0, irq_req}, 64'h0);
        irq_in[50] = 1'b0; tick(2);
        wr(12'h004, 32'h1);
        chk_st("R9 det on level", 5);
        chk("R10 req with both", {63'h0, irq_req}, 64'h1);
        irq_in[5] = 1'b0; tick(3);
        chk_st("R9 no latch while off", 63);
        irq_in[5] = 1'b1; tick(2);

        // R10 output enable
        wr(12'h444, 32'h0);
        chk("R10 out off req", {63'h0, irq_req}, 64'h0);
        chk_st("R10 status kept", 5);
        wr(12'h444, 32'h1);
        chk("R10 out on req", {63'h0, irq_req}, 64'h1);

        // R11 mask-level has no effect on selection
        chk_st("R11 nonzero mask no effect", 5);
        wr(12'h084, 32'h0);
        rd(12'h084, v);    chk("R11 mask zero readback", {32'h0, v}, 64'h0);
        chk_st("R11 zero mask", 5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule